// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block chooses where the two ALU operands of the instruction now in the execute stage of a five-stage in-order pipeline come from. Each operand can come from three places. The first is the register file, as read in decode. The second is the ALU result held in the execute/memory pipeline register. The third is the value held in the memory/writeback pipeline register. The choice is made for each operand on its own. The block compares the operand's source register index with the destination index of each of the two older instructions, taking that instruction's register-write flag into account.

When both older instructions write the register an operand needs, the execute/memory result is taken. It is the more recent value of that register, so the memory/writeback match is suppressed for that operand only. Register 0 always reads as zero, so a destination of 0 never forwards. The select codes and the operand values are purely combinational and settle in the same cycle as their inputs. Stalling on loads, the register file and branch resolution belong to neighbouring blocks.

Top module: `fwd_unit`

## Requirements
- R1: When neither older stage matches an operand, that operand's select is 2'b00 and its output equals its register-file value, including right after reset when all inputs are zero.
- R2: When the execute/memory stage has its write flag set, a nonzero destination, and a destination equal to an operand's source index, that operand's select is 2'b10 and its output equals the execute/memory result.
- R3: When the memory/writeback stage has its write flag set, a nonzero destination, and a destination equal to an operand's source index, and the R2 condition for that operand is false, that operand's select is 2'b01 and its output equals the writeback value.
- R4: When both stages match the same operand, the select is 2'b10: the newer execute/memory result takes priority.
- R5: A stage whose write flag is clear never forwards, even when its destination equals the source index. In that case a match in the other stage still takes effect.
- R6: A stage whose destination index is 0 never forwards, so a source index of 0 always gets select 2'b00.
- R7: Operand A is compared with the first source index (rs) and operand B with the second (rt). The two selects are independent, and in one cycle they may name different stages.
- R8: A select is never 2'b11.
- R9: For the chain add $1,$1,$2; add $1,$1,$3; add $1,$1,$4, the third add's operand A gets the second add's result with select 2'b10, not the first add's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_rs_idx | input | 5 | First source register index of the execute-stage instruction |
| ex_rt_idx | input | 5 | Second source register index of the execute-stage instruction |
| rf_rs_data | input | 32 | Register-file value read for the first source |
| rf_rt_data | input | 32 | Register-file value read for the second source |
| xm_wr_en | input | 1 | Register-write flag in the execute/memory pipeline register |
| xm_dst_idx | input | 5 | Destination index in the execute/memory pipeline register |
| xm_result | input | 32 | ALU result in the execute/memory pipeline register |
| mw_wr_en | input | 1 | Register-write flag in the memory/writeback pipeline register |
| mw_dst_idx | input | 5 | Destination index in the memory/writeback pipeline register |
| mw_value | input | 32 | Value to be written back, held in the memory/writeback pipeline register |
| fwd_sel_a | output | 2 | Select for operand A: 00 register file, 01 writeback, 10 execute/memory |
| fwd_sel_b | output | 2 | Select for operand B, same encoding |
| opnd_a | output | 32 | Selected operand A value |
| opnd_b | output | 32 | Selected operand B value |

## Verification
Two functions can apply in the same cycle. One is forwarding from execute/memory and the other is forwarding from memory/writeback, and they can land on the same operand. The bench provokes this by giving both pipeline registers the operand's source index as destination, once with both write flags set and once with the newer flag cleared. It expects select 2'b10 in the first case and 2'b01 in the second, with the operand value equal to the result of the chosen stage. It also sets up cycles in which operand A and operand B each pick a different stage at once, including the three-add chain, so that the two operands are shown to be decided independently.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  localparam int SEL_W = 2;

  // Operand source codes; the ALU-side mux decodes these values.
  typedef enum logic [SEL_W-1:0] {
    FWD_RF = 2'b00,
    FWD_WB = 2'b01,
    FWD_XM = 2'b10
  } fwd_src_e;

endpackage

// File: rtl/fwd_match.sv
// Compares one producing stage against one source index.
module fwd_match #(
  parameter int IDX_W          = 5,
  parameter bit ZERO_HARDWIRED = 1'b1
) (
  input  logic             wr_en,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic [IDX_W-1:0] src_idx,
  output logic             hit
);

  logic dst_ok;

  generate
    if (ZERO_HARDWIRED) begin : g_zero_guard
      assign dst_ok = (dst_idx != '0);
    end else begin : g_no_guard
      assign dst_ok = 1'b1;
    end
  endgenerate

  assign hit = wr_en && dst_ok && (dst_idx == src_idx);

endmodule

// File: rtl/fwd_prio.sv
// Resolves the two stage matches of one operand into a source code.
module fwd_prio
  import fwd_pkg::*;
(
  input  logic     xm_hit,
  input  logic     mw_hit,
  output fwd_src_e sel
);

  always_comb begin
    if (xm_hit)      sel = FWD_XM;
    else if (mw_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end

endmodule

// File: rtl/fwd_mux.sv
// Three-way operand mux driven by a source code.
module fwd_mux
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwd_src_e          sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] xm_val,
  input  logic [DATA_W-1:0] wb_val,
  output logic [DATA_W-1:0] out_val
);

  always_comb begin
    unique case (sel)
      FWD_XM:  out_val = xm_val;
      FWD_WB:  out_val = wb_val;
      default: out_val = rf_val;
    endcase
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [IDX_W-1:0]  ex_rs_idx,
  input  logic [IDX_W-1:0]  ex_rt_idx,
  input  logic [DATA_W-1:0] rf_rs_data,
  input  logic [DATA_W-1:0] rf_rt_data,
  input  logic              xm_wr_en,
  input  logic [IDX_W-1:0]  xm_dst_idx,
  input  logic [DATA_W-1:0] xm_result,
  input  logic              mw_wr_en,
  input  logic [IDX_W-1:0]  mw_dst_idx,
  input  logic [DATA_W-1:0] mw_value,
  output logic [SEL_W-1:0]  fwd_sel_a,
  output logic [SEL_W-1:0]  fwd_sel_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);

  localparam int NUM_OPND = 2;

  logic [IDX_W-1:0]  src_idx [NUM_OPND];
  logic [DATA_W-1:0] rf_val  [NUM_OPND];
  logic [DATA_W-1:0] out_val [NUM_OPND];
  logic              xm_hit  [NUM_OPND];
  logic              mw_hit  [NUM_OPND];
  fwd_src_e          sel     [NUM_OPND];

  // Operand A follows rs, operand B follows rt.
  assign src_idx[0] = ex_rs_idx;
  assign src_idx[1] = ex_rt_idx;
  assign rf_val[0]  = rf_rs_data;
  assign rf_val[1]  = rf_rt_data;

  generate
    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
      fwd_match #(.IDX_W(IDX_W)) i_xm_match (
        .wr_en   (xm_wr_en),
        .dst_idx (xm_dst_idx),
        .src_idx (src_idx[g]),
        .hit     (xm_hit[g])
      );

      fwd_match #(.IDX_W(IDX_W)) i_mw_match (
        .wr_en   (mw_wr_en),
        .dst_idx (mw_dst_idx),
        .src_idx (src_idx[g]),
        .hit     (mw_hit[g])
      );

      fwd_prio i_prio (
        .xm_hit (xm_hit[g]),
        .mw_hit (mw_hit[g]),
        .sel    (sel[g])
      );

      fwd_mux #(.DATA_W(DATA_W)) i_mux (
        .sel     (sel[g]),
        .rf_val  (rf_val[g]),
        .xm_val  (xm_result),
        .wb_val  (mw_value),
        .out_val (out_val[g])
      );
    end
  endgenerate

  assign fwd_sel_a = sel[0];
  assign fwd_sel_b = sel[1];
  assign opnd_a    = out_val[0];
  assign opnd_b    = out_val[1];

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32
) (
  input logic [IDX_W-1:0]  ex_rs_idx,
  input logic [IDX_W-1:0]  ex_rt_idx,
  input logic [DATA_W-1:0] rf_rs_data,
  input logic [DATA_W-1:0] rf_rt_data,
  input logic              xm_wr_en,
  input logic [IDX_W-1:0]  xm_dst_idx,
  input logic [DATA_W-1:0] xm_result,
  input logic              mw_wr_en,
  input logic [IDX_W-1:0]  mw_dst_idx,
  input logic [DATA_W-1:0] mw_value,
  input logic [1:0]        fwd_sel_a,
  input logic [1:0]        fwd_sel_b,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b
);

  always_comb begin
    // R8: the illegal code never appears
    a_r8_sel_a_legal: assert (fwd_sel_a != 2'b11) else $error("sel_a is 11");
    a_r8_sel_b_legal: assert (fwd_sel_b != 2'b11) else $error("sel_b is 11");

    // R1 / R2 / R3: operand value follows its select
    if (fwd_sel_a == 2'b00)
      a_r1_pass_a: assert (opnd_a == rf_rs_data) else $error("opnd_a not rf");
    if (fwd_sel_b == 2'b00)
      a_r1_pass_b: assert (opnd_b == rf_rt_data) else $error("opnd_b not rf");
    if (fwd_sel_a == 2'b10)
      a_r2_xm_data_a: assert (opnd_a == xm_result) else $error("opnd_a not xm");
    if (fwd_sel_b == 2'b10)
      a_r2_xm_data_b: assert (opnd_b == xm_result) else $error("opnd_b not xm");
    if (fwd_sel_a == 2'b01)
      a_r3_wb_data_a: assert (opnd_a == mw_value) else $error("opnd_a not wb");
    if (fwd_sel_b == 2'b01)
      a_r3_wb_data_b: assert (opnd_b == mw_value) else $error("opnd_b not wb");

    // R5: a forwarding stage must have its write flag set
    if (fwd_sel_a == 2'b10)
      a_r5_xm_wr_a: assert (xm_wr_en) else $error("xm forward without write");
    if (fwd_sel_a == 2'b01)
      a_r5_mw_wr_a: assert (mw_wr_en) else $error("wb forward without write");

    // R6: register 0 is never forwarded
    if (fwd_sel_a != 2'b00)
      a_r6_zero_a: assert (ex_rs_idx != '0) else $error("forward into r0 on A");
    if (fwd_sel_b != 2'b00)
      a_r6_zero_b: assert (ex_rt_idx != '0) else $error("forward into r0 on B");

    // R4: a newer match cannot lose to the older stage
    if (xm_wr_en && xm_dst_idx == ex_rs_idx && fwd_sel_a == 2'b01)
      a_r4_newer_wins_a: assert (xm_dst_idx == '0) else $error("older won on A");
    if (xm_wr_en && xm_dst_idx == ex_rt_idx && fwd_sel_b == 2'b01)
      a_r4_newer_wins_b: assert (xm_dst_idx == '0) else $error("older won on B");

    // R7: operand B's choice tracks rt, not rs
    if (fwd_sel_b == 2'b01)
      a_r7_b_uses_rt: assert (mw_dst_idx == ex_rt_idx) else $error("B matched wrong index");
  end

endmodule

bind fwd_unit fwd_unit_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_fwd_unit_chk (
  .ex_rs_idx  (ex_rs_idx),
  .ex_rt_idx  (ex_rt_idx),
  .rf_rs_data (rf_rs_data),
  .rf_rt_data (rf_rt_data),
  .xm_wr_en   (xm_wr_en),
  .xm_dst_idx (xm_dst_idx),
  .xm_result  (xm_result),
  .mw_wr_en   (mw_wr_en),
  .mw_dst_idx (mw_dst_idx),
  .mw_value   (mw_value),
  .fwd_sel_a  (fwd_sel_a),
  .fwd_sel_b  (fwd_sel_b),
  .opnd_a     (opnd_a),
  .opnd_b     (opnd_b)
);

// File: tb/test_fwd_unit.sv
`timescale 1ns/1ps
module test_fwd_unit;

  localparam int IDX_W  = 5;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [IDX_W-1:0]  ex_rs_idx, ex_rt_idx, xm_dst_idx, mw_dst_idx;
  logic [DATA_W-1:0] rf_rs_data, rf_rt_data, xm_result, mw_value;
  logic              xm_wr_en, mw_wr_en;
  logic [1:0]        fwd_sel_a, fwd_sel_b;
  logic [DATA_W-1:0] opnd_a, opnd_b;

  fwd_unit #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_fwd_unit (
    .ex_rs_idx (ex_rs_idx), .ex_rt_idx (ex_rt_idx),
    .rf_rs_data(rf_rs_data), .rf_rt_data(rf_rt_data),
    .xm_wr_en  (xm_wr_en), .xm_dst_idx(xm_dst_idx), .xm_result(xm_result),
    .mw_wr_en  (mw_wr_en), .mw_dst_idx(mw_dst_idx), .mw_value (mw_value),
    .fwd_sel_a (fwd_sel_a), .fwd_sel_b(fwd_sel_b),
    .opnd_a    (opnd_a), .opnd_b(opnd_b)
  );

  typedef struct {
    string             tag;
    logic [1:0]        sel_a;
    logic [1:0]        sel_b;
    logic [DATA_W-1:0] val_a;
    logic [DATA_W-1:0] val_b;
  } exp_t;

  exp_t sb[$];
  int   checks   = 0;
  int   failures = 0;
  bit   finished = 1'b0;

  localparam logic [DATA_W-1:0] XM_V = 32'hCAFE_0010;
  localparam logic [DATA_W-1:0] WB_V = 32'hBEEF_0001;

  function automatic logic [DATA_W-1:0] pick(input logic [1:0] s, input logic [DATA_W-1:0] rf);
    if (s == 2'b10)      return XM_V;
    else if (s == 2'b01) return WB_V;
    else                 return rf;
  endfunction

  // Driver: applies one cycle of stimulus and queues the expectation.
  task automatic apply(input string tag,
                       input int rs, input int rt,
                       input bit xw, input int xd,
                       input bit mw, input int md,
                       input logic [1:0] ea, input logic [1:0] eb);
    exp_t e;
    @(posedge clk);
    #0.5;
    ex_rs_idx  = IDX_W'(rs);
    ex_rt_idx  = IDX_W'(rt);
    rf_rs_data = 32'h1000_0000 + 32'(rs);
    rf_rt_data = 32'h2000_0000 + 32'(rt);
    xm_wr_en   = xw;
    xm_dst_idx = IDX_W'(xd);
    xm_result  = XM_V;
    mw_wr_en   = mw;
    mw_dst_idx = IDX_W'(md);
    mw_value   = WB_V;
    e.tag   = tag;
    e.sel_a = ea;
    e.sel_b = eb;
    e.val_a = pick(ea, 32'h1000_0000 + 32'(rs));
    e.val_b = pick(eb, 32'h2000_0000 + 32'(rt));
    sb.push_back(e);
  endtask

  task automatic check(input string tag, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: compares outputs mid-cycle against the queued expectation.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, "sel_a", DATA_W'(fwd_sel_a), DATA_W'(e.sel_a));
      check(e.tag, "sel_b", DATA_W'(fwd_sel_b), DATA_W'(e.sel_b));
      check(e.tag, "opnd_a", opnd_a, e.val_a);
      check(e.tag, "opnd_b", opnd_b, e.val_b);
    end
  end

  initial begin
    ex_rs_idx = '0; ex_rt_idx = '0; rf_rs_data = '0; rf_rt_data = '0;
    xm_wr_en = 1'b0; xm_dst_idx = '0; xm_result = '0;
    mw_wr_en = 1'b0; mw_dst_idx = '0; mw_value = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // R1 reset state: all zero, no forwarding
    apply("R1 reset", 0, 0, 0, 0, 0, 0, 2'b00, 2'b00);
    // R1 no hazard
    apply("R1 none", 3, 4, 1, 5, 1, 6, 2'b00, 2'b00);
    // R2 execute/memory only, each operand
    apply("R2 xm A", 7, 4, 1, 7, 0, 0, 2'b10, 2'b00);
    apply("R2 xm B", 3, 7, 1, 7, 1, 2, 2'b00, 2'b10);
    // R3 memory/writeback only on both operands
    apply("R3 wb AB", 8, 8, 1, 2, 1, 8, 2'b01, 2'b01);
    // R4 double hazard on both operands
    apply("R4 double AB", 9, 9, 1, 9, 1, 9, 2'b10, 2'b10);
    // R5 write flag clear on both stages
    apply("R5 noflag", 10, 10, 0, 10, 0, 10, 2'b00, 2'b00);
    // R5 newer flag clear: older match still forwards
    apply("R5 xm off", 11, 11, 0, 11, 1, 11, 2'b01, 2'b01);
    // R6 destination zero on both stages
    apply("R6 dst zero", 0, 0, 1, 0, 1, 0, 2'b00, 2'b00);
    apply("R6 dst zero mixed", 0, 12, 1, 0, 1, 12, 2'b00, 2'b01);
    // R7 operands pick different stages in one cycle
    apply("R7 split", 13, 14, 1, 13, 1, 14, 2'b10, 2'b01);
    apply("R7 split swap", 15, 16, 1, 16, 1, 15, 2'b01, 2'b10);
    // R9 chain: third add, rs=$1 rt=$4, both older adds write $1
    apply("R9 chain", 1, 4, 1, 1, 1, 1, 2'b10, 2'b00);
    // R2 / R3 / R4 sweep over every nonzero index (R8 covered by sel checks)
    for (int i = 1; i < 32; i++) begin
      apply("R2 sweep", i, 32 - i, 1, i, 0, 0, 2'b10, (32 - i == i) ? 2'b10 : 2'b00);
      apply("R3 sweep", 32 - i, i, 0, 0, 1, i, (32 - i == i) ? 2'b01 : 2'b00, 2'b01);
      apply("R4 sweep", i, i, 1, i, 1, i, 2'b10, 2'b10);
    end
    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule